// File: doc/BRIEF.md
# Predicate Scope Unit

This unit governs predicated execution for a short run of instructions after a prefix modifier. The modifier carries three predicate register specifiers and a selector string with one code for each of the next eight instructions. Each specifier holds a register index and an inversion flag. For every issued instruction in the scope, the unit picks the predicate named by that instruction's code, or ignores predication. It then drives a per-lane execute mask and a single execute flag.

The unit has one combinational read port into the predicate register file. It drives the register index and receives that register's lane bits in the same cycle. Register zero is never read: the unit treats it as all ones itself. The modifier arrives on a valid/ready input. The unit never applies back-pressure: `mod_ready` is always high, and a modifier is taken on every cycle in which `mod_valid` is high. The issue strobe and all outputs are plain signals. The outputs describe the instruction presented in the current cycle and depend on the state held before the clock edge.

Top module: `pred_scope_unit`

## Requirements
- R1: After reset no scope is active: `scope_busy` is 0, `lane_en` is all ones, `exec_en` is 1 and `pred_rd_idx` is 0.
- R2: `mod_ready` is always 1. A cycle with `mod_valid` high loads the three specifiers and the selector string. `scope_busy` is 1 from the next cycle, with slot 0 current.
- R3: The code for slot k is `mod_sel[2k+1:2k]`. Code 00 means always execute, which gives all lanes enabled and `pred_rd_idx` 0. Code 01 selects specifier A, 10 selects B and 11 selects C.
- R4: A specifier is {invert bit in the MSB, register index in the lower PREG_W bits}. When a specifier is selected, `pred_rd_idx` equals its index. With the invert bit clear and a non-zero index, `lane_en` equals `pred_rd_val`.
- R5: With the invert bit set and a non-zero index, `lane_en` is the bitwise complement of `pred_rd_val`.
- R6: Index 0 reads as all ones whatever `pred_rd_val` holds. It enables every lane, or no lane when the specifier is inverted.
- R7: `exec_en` is 1 exactly when at least one bit of `lane_en` is 1.
- R8: The current slot advances only on a cycle with `issue` high and no load. After the eighth issue the scope ends and `scope_busy` returns to 0. Cycles without `issue` change nothing.
- R9: A load while a scope is active replaces it and restarts at slot 0. An issue in the same cycle as a load is judged against the scope that was active before the load.
- R10: While no scope is active, issues leave `lane_en` all ones and `scope_busy` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_valid | input | 1 | Modifier present |
| mod_ready | output | 1 | Modifier accepted (always 1) |
| mod_spec_a | input | PREG_W+1 | Specifier A: invert bit MSB, index below |
| mod_spec_b | input | PREG_W+1 | Specifier B |
| mod_spec_c | input | PREG_W+1 | Specifier C |
| mod_sel | input | 2*SLOTS | Selector string, slot 0 in the low bits |
| issue | input | 1 | An instruction issues this cycle |
| pred_rd_idx | output | PREG_W | Predicate register read index |
| pred_rd_val | input | LANES | Lane bits of the register read |
| lane_en | output | LANES | Per-lane execute mask for the current instruction |
| exec_en | output | 1 | Any lane executes |
| scope_busy | output | 1 | A modifier scope is active |

## Verification
A wrong slot count shows up as a selector code applied to the wrong instruction. It also shows up as `scope_busy` dropping early or late, and this appears on the first mis-aligned issue. A corrupted specifier or selector store shows in `pred_rd_idx` and `lane_en` on the next issue that uses it. A stale scope left after a reload appears on the first issue after the load. A reference model runs every cycle, so any of these errors is reported in the cycle where it first reaches a port.

// File: rtl/pscope_pkg.sv
package pscope_pkg;
  typedef enum logic [1:0] {
    CODE_ALWAYS = 2'b00,
    CODE_A      = 2'b01,
    CODE_B      = 2'b10,
    CODE_C      = 2'b11
  } pcode_e;
endpackage

// File: rtl/pscope_ctrl.sv
module pscope_ctrl #(
  parameter int SLOTS  = 8,
  parameter int SPEC_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [SPEC_W-1:0]    spec_a_in,
  input  logic [SPEC_W-1:0]    spec_b_in,
  input  logic [SPEC_W-1:0]    spec_c_in,
  input  logic [2*SLOTS-1:0]   sel_in,
  input  logic                 issue,
  output logic                 busy,
  output logic [1:0]           cur_code,
  output logic [SPEC_W-1:0]    spec_a,
  output logic [SPEC_W-1:0]    spec_b,
  output logic [SPEC_W-1:0]    spec_c
);
  localparam int SEL_W = 2 * SLOTS;
  localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      slot_q <= '0;
      sel_q  <= '0;
      spec_a <= '0;
      spec_b <= '0;
      spec_c <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      slot_q <= '0;
      sel_q  <= sel_in;
      spec_a <= spec_a_in;
      spec_b <= spec_b_in;
      spec_c <= spec_c_in;
    end else if (issue && busy) begin
      sel_q  <= sel_q >> 2;
      slot_q <= slot_q + 1'b1;
      if (slot_q == LAST) busy <= 1'b0;
    end
  end

  assign cur_code = busy ? sel_q[1:0] : 2'b00;
endmodule

// File: rtl/pscope_pick.sv
module pscope_pick #(
  parameter int PREG_W = 3
) (
  input  logic [1:0]      code,
  input  logic [PREG_W:0] spec_a,
  input  logic [PREG_W:0] spec_b,
  input  logic [PREG_W:0] spec_c,
  output logic            use_pred,
  output logic [PREG_W-1:0] idx,
  output logic            inv
);
  import pscope_pkg::*;
  logic [PREG_W:0] chosen;

  always_comb begin
    use_pred = 1'b1;
    unique case (pcode_e'(code))
      CODE_A:  chosen = spec_a;
      CODE_B:  chosen = spec_b;
      CODE_C:  chosen = spec_c;
      default: begin
        chosen   = '0;
        use_pred = 1'b0;
      end
    endcase
    idx = chosen[PREG_W-1:0];
    inv = chosen[PREG_W];
  end
endmodule

// File: rtl/pscope_lane.sv
module pscope_lane #(
  parameter int LANES  = 8,
  parameter int PREG_W = 3
) (
  input  logic              use_pred,
  input  logic [PREG_W-1:0] idx,
  input  logic              inv,
  input  logic [LANES-1:0]  rd_val,
  output logic [LANES-1:0]  mask
);
  logic [LANES-1:0] raw;
  always_comb begin
    raw  = (idx == '0) ? {LANES{1'b1}} : rd_val;
    mask = use_pred ? (raw ^ {LANES{inv}}) : {LANES{1'b1}};
  end
endmodule

// File: rtl/pred_scope_unit.sv
module pred_scope_unit #(
  parameter int LANES  = 8,
  parameter int PREG_W = 3,
  parameter int SLOTS  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mod_valid,
  output logic                 mod_ready,
  input  logic [PREG_W:0]      mod_spec_a,
  input  logic [PREG_W:0]      mod_spec_b,
  input  logic [PREG_W:0]      mod_spec_c,
  input  logic [2*SLOTS-1:0]   mod_sel,
  input  logic                 issue,
  output logic [PREG_W-1:0]    pred_rd_idx,
  input  logic [LANES-1:0]     pred_rd_val,
  output logic [LANES-1:0]     lane_en,
  output logic                 exec_en,
  output logic                 scope_busy
);
  localparam int SPEC_W = PREG_W + 1;

  logic [1:0]        code;
  logic [SPEC_W-1:0] sa, sb, sc;
  logic              use_pred, inv;
  logic [PREG_W-1:0] idx;

  assign mod_ready = 1'b1;

  pscope_ctrl #(.SLOTS(SLOTS), .SPEC_W(SPEC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(mod_valid && mod_ready),
    .spec_a_in(mod_spec_a), .spec_b_in(mod_spec_b), .spec_c_in(mod_spec_c),
    .sel_in(mod_sel), .issue(issue), .busy(scope_busy), .cur_code(code),
    .spec_a(sa), .spec_b(sb), .spec_c(sc)
  );

  pscope_pick #(.PREG_W(PREG_W)) u_pick (
    .code(code), .spec_a(sa), .spec_b(sb), .spec_c(sc),
    .use_pred(use_pred), .idx(idx), .inv(inv)
  );

  pscope_lane #(.LANES(LANES), .PREG_W(PREG_W)) u_lane (
    .use_pred(use_pred), .idx(idx), .inv(inv),
    .rd_val(pred_rd_val), .mask(lane_en)
  );

  assign pred_rd_idx = idx;
  assign exec_en     = |lane_en;
endmodule

// File: rtl/pscope_chk.sv
module pscope_chk #(
  parameter int LANES  = 8,
  parameter int PREG_W = 3,
  parameter int SLOTS  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mod_valid,
  input logic                 mod_ready,
  input logic [PREG_W:0]      mod_spec_a,
  input logic [PREG_W:0]      mod_spec_b,
  input logic [PREG_W:0]      mod_spec_c,
  input logic [2*SLOTS-1:0]   mod_sel,
  input logic                 issue,
  input logic [PREG_W-1:0]    pred_rd_idx,
  input logic [LANES-1:0]     pred_rd_val,
  input logic [LANES-1:0]     lane_en,
  input logic                 exec_en,
  input logic                 scope_busy
);
  int issued;
  always_ff @(posedge clk) begin
    if (!rst_n || mod_valid) issued <= 0;
    else if (issue && scope_busy) issued <= issued + 1;
  end

  assert_idle_all_lanes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !scope_busy |-> (&lane_en && exec_en && pred_rd_idx == '0));

  assert_load_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mod_valid |=> scope_busy);

  assert_zero_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_rd_idx == '0) |-> (&lane_en || lane_en == '0));

  assert_exec_any_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en == '0) |-> !exec_en);

  assert_scope_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scope_busy && issue && !mod_valid && issued == SLOTS - 1) |=> !scope_busy);

  assert_no_issue_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue && !mod_valid) |=> $stable(scope_busy));
endmodule

bind pred_scope_unit pscope_chk #(.LANES(LANES), .PREG_W(PREG_W), .SLOTS(SLOTS)) u_chk (.*);

// File: tb/tb_pred_scope_unit.sv
module tb_pred_scope_unit;
  logic clk = 1'b0;
  logic rst_n;
  logic mod_valid, mod_ready, issue, exec_en, scope_busy;
  logic [3:0] mod_spec_a, mod_spec_b, mod_spec_c;
  logic [15:0] mod_sel;
  logic [2:0] pred_rd_idx;
  logic [7:0] pred_rd_val, lane_en;
  logic [7:0] pregs [8];

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit m_busy;
  int m_slot;
  logic [3:0] m_a, m_b, m_c;
  logic [15:0] m_sel;

  always #2 clk = ~clk;

  always_comb pred_rd_val = pregs[pred_rd_idx];

  pred_scope_unit dut (.*);

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit mv, logic [3:0] a, logic [3:0] b,
                      logic [3:0] c, logic [15:0] sel, bit iss);
    logic [7:0] e_lane;
    logic [2:0] e_idx;
    logic [3:0] sp;
    logic [7:0] raw;
    @(negedge clk);
    mod_valid = mv; mod_spec_a = a; mod_spec_b = b; mod_spec_c = c;
    mod_sel = sel; issue = iss;
    #1;
    e_lane = 8'hFF; e_idx = 3'd0;
    if (m_busy && m_sel[1:0] != 2'b00) begin
      sp = (m_sel[1:0] == 2'b01) ? m_a : (m_sel[1:0] == 2'b10) ? m_b : m_c;
      e_idx = sp[2:0];
      raw = (e_idx == 0) ? 8'hFF : pregs[e_idx];
      e_lane = sp[3] ? ~raw : raw;
    end
    chk(tag, "lane_en", lane_en, e_lane);
    chk(tag, "pred_rd_idx", pred_rd_idx, e_idx);
    chk(tag, "exec_en", exec_en, e_lane != 0);
    chk(tag, "scope_busy", scope_busy, m_busy);
    chk("R2", "mod_ready", mod_ready, 1);
    @(posedge clk);
    if (mv) begin
      m_busy = 1; m_slot = 0; m_a = a; m_b = b; m_c = c; m_sel = sel;
    end else if (iss && m_busy) begin
      m_sel = m_sel >> 2;
      m_slot++;
      if (m_slot == 8) m_busy = 0;
    end
  endtask

  task automatic idle(string tag, int n, bit iss);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, iss);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    pregs[0] = 8'h00; pregs[1] = 8'hA5; pregs[2] = 8'h0F; pregs[3] = 8'h81;
    pregs[4] = 8'h00; pregs[5] = 8'hFF; pregs[6] = 8'h3C; pregs[7] = 8'h01;
    m_busy = 0; m_slot = 0; m_a = 0; m_b = 0; m_c = 0; m_sel = 0;
    mod_valid = 0; issue = 0; mod_spec_a = 0; mod_spec_b = 0; mod_spec_c = 0; mod_sel = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state, R10 issues with no scope
    idle("R1", 2, 0);
    idle("R10", 3, 1);
    // R3 R4 R5: all codes, A=r1, B=~r2, C=r6; string slot0..7: 1,2,3,0,3,2,1,0
    step("R3", 1, 4'h1, 4'hA, 4'h6, 16'b00_01_10_11_00_11_10_01, 0);
    idle("R4", 2, 0);               // R8 no advance without issue
    idle("R5", 8, 1);               // R8 ends after eighth issue
    idle("R8", 2, 1);
    // R6 register zero plain and inverted, and inverted zero-valued register
    step("R6", 1, 4'h0, 4'h8, 4'hC, 16'h1B1B, 0);
    idle("R6", 8, 1);
    // R9 reload mid scope, and issue in same cycle as load
    step("R9", 1, 4'h3, 4'h7, 4'hD, 16'hFFFF, 0);
    idle("R9", 3, 1);
    step("R9", 1, 4'h2, 4'h9, 4'h5, 16'h5555, 1);
    idle("R9", 9, 1);
    // R7 zero lane mask gives exec low: r4 is zero
    step("R7", 1, 4'h4, 4'hD, 4'h5, 16'h00F5, 0);
    idle("R7", 8, 1);
    // mixed patterns
    lcg = 32'h1234_5678;
    for (int k = 0; k < 300; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (lcg[31:29] == 0)
        step("R8", 1, lcg[3:0], lcg[7:4], lcg[11:8], lcg[27:12], lcg[28]);
      else
        step("R8", 0, 0, 0, 0, 0, lcg[20]);
      if (lcg[15:13] == 0) pregs[lcg[2:0]] = lcg[23:16];
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule